// File: doc/BRIEF.md
# Two-Level Multibit Feedback Pulse-Width Controller

This block closes the digital half of a first-order charge-balancing loop. An external coarse converter samples the integrator voltage and hands over a code. The block turns that code into the on-time of one switch-control line. High means the positive reference current is steered into the integrator. Low means the negative one is. There are only two physical levels. The multibit resolution comes entirely from where the switch edge falls inside a fixed-length frame.

Each frame is divided into 64 equal slots. A small pseudo-random dither may be added to the coarse code, clamped at full scale, and then only the upper six bits are kept. The result fixes how many slots of the next frame drive positive charge. A larger code means the integrator sits higher, so the block injects less positive charge and so opposes the integrator's sign. New codes take effect only at frame boundaries. The code actually used in each frame is reported with a one-cycle strobe, so a downstream decimation filter can account for exactly the charge injected.

States of the control machine: `PH_DRIVE_POS` (switch drives positive reference) and `PH_DRIVE_NEG` (switch drives negative reference). Transitions: POS→NEG when the next slot index reaches the frame's applied code; NEG→POS, or POS→POS, at a frame boundary when the new applied code is non-zero; POS→NEG at a frame boundary when the new applied code is zero.

Top module: `pwm_fb_ctrl`

## Requirements
- R1: While reset is held and in the first frame after reset, the applied code is 32: `sw_pos` is high for slots 0..31 and low for slots 32..63, and `app_vld` stays low through reset and the whole first frame.
- R2: A frame is 64 slots of `SLOT_CYC` clock cycles each. At the first cycle of every frame after the first, `app_vld` pulses high for exactly one cycle and `app_code` carries the 6-bit code applied in that frame.
- R3: With applied code k (0..63), `sw_pos` is high for the first k slots of the frame and low for the remaining 64−k slots. It rises only at slot 0.
- R4: With dither disabled, the coarse code (8-bit, offset binary, larger means the integrator is more positive) maps to k = 63 − code[7:2], so bits [1:0] are discarded.
- R5: A code presented with `coarse_vld` during a frame does not change that frame's duty. It is applied in the next frame, and the last code presented in a frame wins.
- R6: When no code arrives during a frame, the next frame repeats the previous applied code and still pulses `app_vld`.
- R7: With `dither_en` high at a frame boundary where a code is taken, a value d in 0..3 is added to the code before truncation. d is the low two bits of a 16-bit LFSR with taps 16,14,13,11 that steps once per taken code. So k is either 63 − code[7:2] or one less.
- R8: The dithered sum clamps at 255, so any code of 252 or above gives k = 0 and the output never wraps to a large positive duty.
- R9: A code presented in the last cycle of a frame is applied in the frame that starts immediately after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slot clock |
| rst | input | 1 | Synchronous reset, active high |
| coarse_code | input | 8 | Sampled integrator code, offset binary |
| coarse_vld | input | 1 | Strobe marking `coarse_code` as new |
| dither_en | input | 1 | Enables dither addition before truncation |
| sw_pos | output | 1 | Switch control: 1 = positive reference, 0 = negative |
| app_code | output | 6 | Positive-slot count applied in the current frame |
| app_vld | output | 1 | One-cycle strobe at frame start for `app_code` |

## Verification
The assertions assume `coarse_vld` is a plain strobe whose code is stable in the cycle it is high, and that `dither_en` is a clean level. They also assume the slot divider is at least one cycle, so a frame always lasts far longer than two cycles. The stimulus only changes inputs on the falling clock edge and holds each strobe for a single cycle. It places codes at chosen slot positions: early, late, twice in one frame, and in the final slot. This keeps every arrival inside the assumed strobe discipline while still reaching the boundary-timing corners.

// File: rtl/pwm_fb_pkg.sv
package pwm_fb_pkg;
    typedef enum logic {
        PH_DRIVE_POS = 1'b1,
        PH_DRIVE_NEG = 1'b0
    } fb_phase_e;
endpackage

// File: rtl/fb_dither_lfsr.sv
module fb_dither_lfsr #(
    parameter int LFSR_W = 16,
    parameter int DITH_W = 2,
    parameter logic [LFSR_W-1:0] SEED = 16'hACE1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              step,
    output logic [DITH_W-1:0] dith
);
    logic [LFSR_W-1:0] lfsr_q;
    logic              fb_bit;

    // taps 16,14,13,11
    assign fb_bit = lfsr_q[15] ^ lfsr_q[13] ^ lfsr_q[12] ^ lfsr_q[10];

    always_ff @(posedge clk) begin
        if (rst)       lfsr_q <= SEED;
        else if (step) lfsr_q <= {lfsr_q[LFSR_W-2:0], fb_bit};
    end

    assign dith = lfsr_q[DITH_W-1:0];

    // R7: the register must never lock up in the all-zero state
    a_r7_lfsr_live: assert property (@(posedge clk) disable iff (rst)
        lfsr_q != '0);
endmodule

// File: rtl/fb_code_quant.sv
module fb_code_quant #(
    parameter int CODE_W = 8,
    parameter int DUTY_W = 6,
    parameter int DITH_W = 2
) (
    input  logic [CODE_W-1:0] code,
    input  logic [DITH_W-1:0] dith,
    input  logic              dith_en,
    output logic [DUTY_W-1:0] duty_k
);
    localparam int SUM_W = CODE_W + 1;
    localparam logic [CODE_W-1:0] FULL = '1;

    logic [SUM_W-1:0]  sum;
    logic [CODE_W-1:0] clamped;
    logic [DUTY_W-1:0] upper;

    always_comb begin
        sum = {1'b0, code} + (dith_en ? SUM_W'(dith) : SUM_W'(0));
        clamped = sum[CODE_W] ? FULL : sum[CODE_W-1:0];
        upper = clamped[CODE_W-1 -: DUTY_W];
        duty_k = ~upper;
    end

    always_comb begin
        // R8: top-of-range code always yields zero positive slots
        if (&code[CODE_W-1 -: DUTY_W])
            a_r8_clamp_top: assert (duty_k == '0);
        // R7: dither moves the truncated code by at most one step
        a_r7_dither_span: assert ((~duty_k) == code[CODE_W-1 -: DUTY_W] ||
                                  (~duty_k) == code[CODE_W-1 -: DUTY_W] + DUTY_W'(1));
    end
endmodule

// File: rtl/fb_frame_timer.sv
module fb_frame_timer #(
    parameter int DUTY_W   = 6,
    parameter int SLOT_CYC = 1
) (
    input  logic              clk,
    input  logic              rst,
    output logic [DUTY_W-1:0] slot_idx,
    output logic              slot_tick,
    output logic              frame_end
);
    localparam logic [DUTY_W-1:0] LAST_SLOT = '1;

    generate
        if (SLOT_CYC == 1) begin : g_direct
            assign slot_tick = 1'b1;
        end else begin : g_prescale
            localparam int PW = $clog2(SLOT_CYC);
            logic [PW-1:0] pre_q;
            always_ff @(posedge clk) begin
                if (rst)                                pre_q <= '0;
                else if (pre_q == PW'(SLOT_CYC - 1))    pre_q <= '0;
                else                                    pre_q <= pre_q + PW'(1);
            end
            assign slot_tick = (pre_q == PW'(SLOT_CYC - 1));
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst)            slot_idx <= '0;
        else if (slot_tick) slot_idx <= slot_idx + DUTY_W'(1);
    end

    assign frame_end = slot_tick && (slot_idx == LAST_SLOT);
endmodule

// File: rtl/pwm_fb_ctrl.sv
module pwm_fb_ctrl #(
    parameter int CODE_W     = 8,
    parameter int DUTY_W     = 6,
    parameter int DITH_W     = 2,
    parameter int SLOT_CYC   = 1,
    parameter int RESET_DUTY = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CODE_W-1:0] coarse_code,
    input  logic              coarse_vld,
    input  logic              dither_en,
    output logic              sw_pos,
    output logic [DUTY_W-1:0] app_code,
    output logic              app_vld
);
    import pwm_fb_pkg::*;

    localparam logic [DUTY_W-1:0] K_RESET = DUTY_W'(RESET_DUTY);

    logic [DUTY_W-1:0] slot_idx;
    logic              slot_tick;
    logic              frame_end;
    logic [CODE_W-1:0] pend_code;
    logic              pend_flag;
    logic [CODE_W-1:0] take_code;
    logic              have_code;
    logic [DITH_W-1:0] dith;
    logic [DUTY_W-1:0] quant_k;
    logic [DUTY_W-1:0] k_new;
    logic [DUTY_W-1:0] cur_k;
    fb_phase_e         state_q, state_d;

    fb_frame_timer #(.DUTY_W(DUTY_W), .SLOT_CYC(SLOT_CYC)) timer_i (
        .clk(clk), .rst(rst), .slot_idx(slot_idx),
        .slot_tick(slot_tick), .frame_end(frame_end)
    );

    fb_dither_lfsr #(.DITH_W(DITH_W)) lfsr_i (
        .clk(clk), .rst(rst), .step(frame_end && have_code), .dith(dith)
    );

    fb_code_quant #(.CODE_W(CODE_W), .DUTY_W(DUTY_W), .DITH_W(DITH_W)) quant_i (
        .code(take_code), .dith(dith), .dith_en(dither_en), .duty_k(quant_k)
    );

    // newest code wins; a strobe in the boundary cycle goes straight through
    always_ff @(posedge clk) begin
        if (rst) begin
            pend_flag <= 1'b0;
            pend_code <= '0;
        end else if (frame_end) begin
            pend_flag <= 1'b0;
        end else if (coarse_vld) begin
            pend_flag <= 1'b1;
            pend_code <= coarse_code;
        end
    end

    assign take_code = coarse_vld ? coarse_code : pend_code;
    assign have_code = coarse_vld || pend_flag;
    assign k_new     = have_code ? quant_k : cur_k;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PH_DRIVE_POS: begin
                if (frame_end)
                    state_d = (k_new != '0) ? PH_DRIVE_POS : PH_DRIVE_NEG;
                else if (slot_tick &&
                         ({1'b0, slot_idx} + (DUTY_W+1)'(1)) >= {1'b0, cur_k})
                    state_d = PH_DRIVE_NEG;
            end
            PH_DRIVE_NEG: begin
                if (frame_end && k_new != '0)
                    state_d = PH_DRIVE_POS;
            end
            default: state_d = PH_DRIVE_NEG;
        endcase
    end

    // state register and per-frame code
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= (K_RESET != '0) ? PH_DRIVE_POS : PH_DRIVE_NEG;
            cur_k   <= K_RESET;
        end else begin
            state_q <= state_d;
            if (frame_end) cur_k <= k_new;
        end
    end

    // outputs
    always_ff @(posedge clk) begin
        if (rst) begin
            app_vld  <= 1'b0;
            app_code <= K_RESET;
        end else begin
            app_vld <= frame_end;
            if (frame_end) app_code <= k_new;
        end
    end

    always_comb sw_pos = (state_q == PH_DRIVE_POS);

    // R3: positive interval begins only at the first slot of a frame
    a_r3_rise_at_start: assert property (@(posedge clk) disable iff (rst)
        $rose(sw_pos) |-> slot_idx == '0);
    // R3: switch is positive only inside the first k slots
    a_r3_pos_inside_k: assert property (@(posedge clk) disable iff (rst)
        sw_pos |-> slot_idx < cur_k);
    // R5: duty frozen except across a frame boundary
    a_r5_duty_frozen: assert property (@(posedge clk) disable iff (rst)
        !frame_end |=> $stable(cur_k));
    // R2: report strobe sits on slot zero and lasts one cycle
    a_r2_vld_at_slot0: assert property (@(posedge clk) disable iff (rst)
        app_vld |-> slot_idx == '0);
    a_r2_vld_single: assert property (@(posedge clk) disable iff (rst)
        app_vld |=> !app_vld);
    // R2: reported code matches the one steering the switch
    a_r2_report_match: assert property (@(posedge clk) disable iff (rst)
        app_vld |-> app_code == cur_k);
endmodule

// File: tb/pwm_fb_ctrl_tb_top.sv
module pwm_fb_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] coarse_code = '0;
    logic       coarse_vld = 1'b0;
    logic       dither_en = 1'b0;
    logic       sw_pos;
    logic [5:0] app_code;
    logic       app_vld;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #5 clk = ~clk;

    pwm_fb_ctrl dut_i (
        .clk(clk), .rst(rst), .coarse_code(coarse_code), .coarse_vld(coarse_vld),
        .dither_en(dither_en), .sw_pos(sw_pos), .app_code(app_code), .app_vld(app_vld)
    );

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            checks++; errors++;
            $display("FAIL watchdog: actual %0d cycles expected < 100000", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int exp_k(input logic [7:0] c);
        return 63 - int'(c[7:2]);
    endfunction

    // Runs one frame starting at slot 0 (negedge); ends at slot 0 of the next frame.
    task automatic run_frame(input int ia, input logic [7:0] ca,
                             input int ib, input logic [7:0] cb,
                             output int npos, output bit ordered,
                             output bit vstart, output int kapp);
        bit seen_low = 0;
        npos = 0; ordered = 1;
        vstart = app_vld; kapp = int'(app_code);
        for (int s = 0; s < 64; s++) begin
            if (sw_pos) begin
                npos++;
                if (seen_low) ordered = 0;
            end else seen_low = 1;
            if (s == ia)      begin coarse_code = ca; coarse_vld = 1'b1; end
            else if (s == ib) begin coarse_code = cb; coarse_vld = 1'b1; end
            else              coarse_vld = 1'b0;
            if (s < 63) @(negedge clk);
        end
        @(negedge clk);
        coarse_vld = 1'b0;
    endtask

    int  np, ka;
    bit  ord, vs;

    task automatic t_reset();
        @(negedge clk);
        check(sw_pos == 1'b1, "R1 sw_pos in reset", sw_pos, 1);
        check(app_vld == 1'b0, "R1 app_vld in reset", app_vld, 0);
        rst = 1'b0;
        run_frame(-1, 0, -1, 0, np, ord, vs, ka);
        check(np == 32, "R1 first frame positive slots", np, 32);
        check(ord, "R1 first frame positive-first", ord, 1);
        check(!vs, "R1 no strobe in first frame", vs, 0);
    endtask

    task automatic t_hold_and_late_code();
        // frame 1: repeat of reset code; a code lands mid-frame
        run_frame(10, 8'h40, -1, 0, np, ord, vs, ka);
        check(vs, "R6 strobe on held frame", vs, 1);
        check(ka == 32, "R6 held code", ka, 32);
        check(np == 32, "R5 mid-frame code leaves duty", np, 32);
        run_frame(-1, 0, -1, 0, np, ord, vs, ka);
        check(ka == exp_k(8'h40), "R4 code 0x40 mapping", ka, exp_k(8'h40));
        check(np == exp_k(8'h40) && ord, "R3 duty for 0x40", np, exp_k(8'h40));
        check(vs, "R2 strobe each frame", vs, 1);
    endtask

    task automatic t_extremes();
        run_frame(3, 8'h00, -1, 0, np, ord, vs, ka);
        run_frame(5, 8'h80, -1, 0, np, ord, vs, ka);
        check(ka == 63 && np == 63 && ord, "R3 code 0x00 gives 63 slots", np, 63);
        run_frame(7, 8'hFF, -1, 0, np, ord, vs, ka);
        check(ka == 31 && np == 31, "R4 mid-scale 0x80", np, 31);
        run_frame(-1, 0, -1, 0, np, ord, vs, ka);
        check(ka == 0 && np == 0, "R3 code 0xFF gives zero slots", np, 0);
    endtask

    task automatic t_last_wins();
        run_frame(5, 8'h10, 30, 8'hC0, np, ord, vs, ka);
        run_frame(-1, 0, -1, 0, np, ord, vs, ka);
        check(ka == exp_k(8'hC0), "R5 last code wins", ka, exp_k(8'hC0));
        check(np == exp_k(8'hC0), "R5 duty of last code", np, exp_k(8'hC0));
    endtask

    task automatic t_boundary();
        run_frame(63, 8'h20, -1, 0, np, ord, vs, ka);
        check(np == exp_k(8'hC0), "R9 frame before boundary code", np, exp_k(8'hC0));
        run_frame(-1, 0, -1, 0, np, ord, vs, ka);
        check(ka == exp_k(8'h20), "R9 boundary code applied next frame", ka, exp_k(8'h20));
        check(np == exp_k(8'h20) && ord, "R9 duty of boundary code", np, exp_k(8'h20));
    endtask

    task automatic t_dither();
        int bumped = 0;
        bit in_span = 1;
        bit flat = 1;
        dither_en = 1'b1;
        run_frame(4, 8'h43, -1, 0, np, ord, vs, ka);
        for (int i = 0; i < 16; i++) begin
            run_frame(4, 8'h43, -1, 0, np, ord, vs, ka);
            if (ka != 47 && ka != 46) in_span = 0;
            if (ka == 46) bumped++;
            if (np != ka) in_span = 0;
        end
        check(in_span, "R7 dithered code within one step", ka, 47);
        check(bumped > 0, "R7 dither changes truncated code", bumped, 1);
        run_frame(4, 8'h40, -1, 0, np, ord, vs, ka);
        for (int i = 0; i < 6; i++) begin
            run_frame(4, 8'h40, -1, 0, np, ord, vs, ka);
            if (ka != 47) flat = 0;
        end
        check(flat, "R7 dither below carry keeps code", ka, 47);
    endtask

    task automatic t_clamp();
        bit clamped = 1;
        run_frame(2, 8'hFE, -1, 0, np, ord, vs, ka);
        for (int i = 0; i < 6; i++) begin
            run_frame(2, 8'hFE, -1, 0, np, ord, vs, ka);
            if (ka != 0 || np != 0) clamped = 0;
        end
        check(clamped, "R8 clamp at top, no wrap", np, 0);
        run_frame(-1, 0, -1, 0, np, ord, vs, ka);
        run_frame(-1, 0, -1, 0, np, ord, vs, ka);
        check(vs && ka == 0 && np == 0, "R6 hold after clamp", ka, 0);
        dither_en = 1'b0;
        run_frame(9, 8'h80, -1, 0, np, ord, vs, ka);
        run_frame(-1, 0, -1, 0, np, ord, vs, ka);
        check(ka == 31 && np == 31, "R4 dither off again", ka, 31);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        t_reset();
        t_hold_and_late_code();
        t_extremes();
        t_last_wins();
        t_boundary();
        t_dither();
        t_clamp();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule